// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block handles the addressing phase of an I2C slave. It does not touch the bus lines. A front end decodes the bus into one-cycle event strobes: start (which also covers a repeated start), stop, and a received byte with its value. The block compares each address byte against its own configured address. It then decides whether the receiver should acknowledge and emits a one-cycle acknowledge request. On a full match it sets a sticky address-matched flag, which software clears with a strobe. An event interrupt mirrors the flag when interrupts are enabled.

In 7-bit mode the upper seven bits of the first byte are compared against the own address. The least significant bit of that byte gives the direction. A second 7-bit address can be enabled as well, and a status output shows which of the two addresses was accepted.

In 10-bit mode the first byte is a header of the form 11110 followed by the two high address bits and a direction bit. A write header is acknowledged, and the following byte must then equal the low eight address bits. A completed 10-bit match always leaves the slave receiving. The slave becomes a transmitter only when a repeated start is followed by a read header, and only if the full 10-bit address has already matched earlier in the same transfer. A stop clears the direction and forgets the earlier 10-bit match.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: After reset, ackOut, addrFlag, evtIrq, dualHit and isTransmit are all 0.
- R2: In 7-bit mode (cfgTenBit=0), the first byte after a start matches when byteData[7:1] equals cfgAddr[6:0]. ackOut pulses in the cycle after byteValid when cfgAckEn=1. addrFlag rises one cycle after that pulse. isTransmit takes byteData[0] (1 = transmit) and dualHit becomes 0.
- R3: If the first byte after a start does not match, there is no acknowledge and no flag. Every later byte is ignored until the next start, including a byte whose value would have matched.
- R4: When cfgDualEn=1, a first byte with byteData[7:1] equal to cfgAddr2 matches in either mode, with the direction taken from byteData[0] and dualHit set to 1. When cfgDualEn=0, such a byte is not acknowledged.
- R5: In 10-bit mode a first byte equal to {5'b11110, cfgAddr[9:8], 1'b0} is acknowledged without setting the flag. The next byte then matches if it equals cfgAddr[7:0]. On that match the block acknowledges, sets addrFlag and drives isTransmit to 0.
- R6: After a full 10-bit match, a repeated start followed by {5'b11110, cfgAddr[9:8], 1'b1} in the same transfer is acknowledged. It sets addrFlag and drives isTransmit to 1.
- R7: A 10-bit read header is not acknowledged if no full 10-bit match has happened since the last stop.
- R8: A stop drives isTransmit to 0 within two cycles and clears the memory of an earlier 10-bit match.
- R9: With cfgAckEn=0, a matching address produces no ackOut pulse, but addrFlag is still set.
- R10: addrFlag stays 1 until a flagClr pulse. evtIrq equals addrFlag when cfgEvtIrqEn=1 and is 0 otherwise.
- R11: In 10-bit mode a wrong header (high bits differ) or a wrong low byte after a good header gives no flag. The wrong low byte also gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTenBit | input | 1 | 1 selects 10-bit own address |
| cfgDualEn | input | 1 | Enables the second 7-bit address |
| cfgAckEn | input | 1 | Enables acknowledge requests |
| cfgEvtIrqEn | input | 1 | Enables the event interrupt |
| cfgAddr | input | 10 | Own address (7-bit mode uses bits 6:0) |
| cfgAddr2 | input | 7 | Second 7-bit own address |
| evStart | input | 1 | Start or repeated start strobe |
| evStop | input | 1 | Stop strobe |
| byteValid | input | 1 | Received byte strobe |
| byteData | input | 8 | Received byte, MSB first on the bus |
| flagClr | input | 1 | Clears addrFlag |
| ackOut | output | 1 | One-cycle acknowledge request |
| addrFlag | output | 1 | Sticky address-matched flag |
| evtIrq | output | 1 | Event interrupt |
| dualHit | output | 1 | 1 when the second address was accepted |
| isTransmit | output | 1 | 1 when the slave transmits |

## Verification
The bench tests the primary 7-bit address in both directions and the second address with dual mode on and off. A plain mismatch is followed by a matching byte without a start, which shows that ignoring lasts until the next start. The 10-bit patterns cover a write header with a correct or wrong low byte, a header with wrong high bits, and a read header after a repeated start. A read header after a stop shows that the earlier-match memory really is cleared. Runs with acknowledge disabled and interrupt disabled separate the acknowledge request and the interrupt from the flag itself.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FIRST,
    PH_LOW,
    PH_DONE
  } phase_e;

  // compare results from datapath to control
  typedef struct packed {
    logic hdrWr;
    logic hdrRd;
    logic primary7;
    logic second7;
    logic low8;
    logic tenSeen;
  } hits_t;

  // strobes from control to datapath
  typedef struct packed {
    logic match;
    logic txSet;
    logic dualSel;
    logic tenSet;
    logic busEnd;
  } strobe_t;

endpackage

// File: rtl/i2c_addr_datapath.sv
module i2c_addr_datapath
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int BYTE_W       = 8,
  parameter bit DUAL_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [BYTE_W-2:0] cfgAddr2,
  input  logic              cfgDualEn,
  input  logic              cfgEvtIrqEn,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              flagClr,
  input  strobe_t           strobe,
  output hits_t             hits,
  output logic              addrFlag,
  output logic              evtIrq,
  output logic              dualHit,
  output logic              isTransmit
);

  localparam int SHORT_W  = BYTE_W - 1;
  localparam int HI_W     = ADDR_W - BYTE_W;
  localparam int PREFIX_W = BYTE_W - 1 - HI_W;
  localparam logic [PREFIX_W-1:0] HDR_PREFIX = PREFIX_W'((1 << PREFIX_W) - 2);

  logic tenSeen;
  logic hdrMatch;
  logic second7;

  assign hdrMatch = (byteData[BYTE_W-1 -: PREFIX_W] == HDR_PREFIX) &&
                    (byteData[HI_W:1] == cfgAddr[ADDR_W-1 -: HI_W]);

  generate
    if (DUAL_SUPPORT) begin : g_dual
      assign second7 = cfgDualEn && (byteData[BYTE_W-1:1] == cfgAddr2);
    end else begin : g_single
      assign second7 = 1'b0;
    end
  endgenerate

  always_comb begin
    hits.hdrWr    = hdrMatch & ~byteData[0];
    hits.hdrRd    = hdrMatch & byteData[0];
    hits.primary7 = (byteData[BYTE_W-1:1] == cfgAddr[SHORT_W-1:0]);
    hits.second7  = second7;
    hits.low8     = (byteData == cfgAddr[BYTE_W-1:0]);
    hits.tenSeen  = tenSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrFlag   <= 1'b0;
      isTransmit <= 1'b0;
      dualHit    <= 1'b0;
      tenSeen    <= 1'b0;
    end else begin
      if (strobe.match)  addrFlag <= 1'b1;
      else if (flagClr)  addrFlag <= 1'b0;

      if (strobe.busEnd) begin
        isTransmit <= 1'b0;
        tenSeen    <= 1'b0;
      end else begin
        if (strobe.match) begin
          isTransmit <= strobe.txSet;
          dualHit    <= strobe.dualSel;
        end
        if (strobe.tenSet) tenSeen <= 1'b1;
      end
    end
  end

  assign evtIrq = addrFlag & cfgEvtIrqEn;

endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgTenBit,
  input  logic    cfgAckEn,
  input  logic    evStart,
  input  logic    evStop,
  input  logic    byteValid,
  input  logic    byteRw,
  input  hits_t   hits,
  output logic    ackPulse,
  output strobe_t strobe
);

  phase_e  phase, nextPhase;
  strobe_t nextStrobe;
  logic    nextAck;

  always_comb begin
    nextPhase  = phase;
    nextStrobe = '0;
    nextAck    = 1'b0;
    if (evStop) begin
      nextPhase         = PH_IDLE;
      nextStrobe.busEnd = 1'b1;
    end else if (evStart) begin
      nextPhase = PH_FIRST;
    end else if (byteValid) begin
      unique case (phase)
        PH_FIRST: begin
          if (cfgTenBit && hits.hdrWr) begin
            nextAck   = cfgAckEn;
            nextPhase = PH_LOW;
          end else if (cfgTenBit && hits.hdrRd && hits.tenSeen) begin
            nextAck          = cfgAckEn;
            nextStrobe.match = 1'b1;
            nextStrobe.txSet = 1'b1;
            nextPhase        = PH_DONE;
          end else if (!cfgTenBit && hits.primary7) begin
            nextAck          = cfgAckEn;
            nextStrobe.match = 1'b1;
            nextStrobe.txSet = byteRw;
            nextPhase        = PH_DONE;
          end else if (hits.second7) begin
            nextAck            = cfgAckEn;
            nextStrobe.match   = 1'b1;
            nextStrobe.txSet   = byteRw;
            nextStrobe.dualSel = 1'b1;
            nextPhase          = PH_DONE;
          end else begin
            nextPhase = PH_IDLE;
          end
        end
        PH_LOW: begin
          if (hits.low8) begin
            nextAck           = cfgAckEn;
            nextStrobe.match  = 1'b1;
            nextStrobe.tenSet = 1'b1;
            nextPhase         = PH_DONE;
          end else begin
            nextPhase = PH_IDLE;
          end
        end
        default: nextPhase = phase;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      strobe   <= '0;
      ackPulse <= 1'b0;
    end else begin
      phase    <= nextPhase;
      strobe   <= nextStrobe;
      ackPulse <= nextAck;
    end
  end

endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int BYTE_W       = 8,
  parameter bit DUAL_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgTenBit,
  input  logic              cfgDualEn,
  input  logic              cfgAckEn,
  input  logic              cfgEvtIrqEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [BYTE_W-2:0] cfgAddr2,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              flagClr,
  output logic              ackOut,
  output logic              addrFlag,
  output logic              evtIrq,
  output logic              dualHit,
  output logic              isTransmit
);

  hits_t   hits;
  strobe_t strobe;

  i2c_addr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgTenBit(cfgTenBit),
    .cfgAckEn (cfgAckEn),
    .evStart  (evStart),
    .evStop   (evStop),
    .byteValid(byteValid),
    .byteRw   (byteData[0]),
    .hits     (hits),
    .ackPulse (ackOut),
    .strobe   (strobe)
  );

  i2c_addr_datapath #(
    .ADDR_W      (ADDR_W),
    .BYTE_W      (BYTE_W),
    .DUAL_SUPPORT(DUAL_SUPPORT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgAddr    (cfgAddr),
    .cfgAddr2   (cfgAddr2),
    .cfgDualEn  (cfgDualEn),
    .cfgEvtIrqEn(cfgEvtIrqEn),
    .byteData   (byteData),
    .flagClr    (flagClr),
    .strobe     (strobe),
    .hits       (hits),
    .addrFlag   (addrFlag),
    .evtIrq     (evtIrq),
    .dualHit    (dualHit),
    .isTransmit (isTransmit)
  );

endmodule

// File: rtl/i2c_addr_checker.sv
module i2c_addr_checker (
  input logic clk,
  input logic rstN,
  input logic cfgAckEn,
  input logic cfgDualEn,
  input logic evStop,
  input logic byteValid,
  input logic flagClr,
  input logic ackOut,
  input logic addrFlag,
  input logic dualHit,
  input logic isTransmit
);

  // ack request only answers a received byte, and only when enabled (R2, R9)
  p_ack_follows_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> $past(byteValid) && $past(cfgAckEn));

  // flag rises only after the acknowledge request when ack is enabled (R2)
  p_ack_before_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrFlag) && cfgAckEn |-> $past(ackOut));

  // second address can only be reported while dual mode is on (R4)
  p_dual_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dualHit) |-> cfgDualEn);

  // stop returns the slave to receiving (R8)
  p_stop_clears_tx_r8: assert property (@(posedge clk) disable iff (!rstN)
    evStop |-> ##2 !isTransmit);

  // flag is sticky until cleared (R10)
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(addrFlag) && !$past(flagClr) |-> addrFlag);

endmodule

bind i2c_addr_recognizer i2c_addr_checker u_chk (.*);

// File: tb/test_i2c_addr_recognizer.sv
module test_i2c_addr_recognizer;

  typedef struct {
    bit    ack;
    bit    match;
    bit    tx;
    bit    dual;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgTenBit = 1'b0;
  logic       cfgDualEn = 1'b1;
  logic       cfgAckEn = 1'b1;
  logic       cfgEvtIrqEn = 1'b1;
  logic [9:0] cfgAddr = 10'h03A;
  logic [6:0] cfgAddr2 = 7'h51;
  logic       evStart = 1'b0;
  logic       evStop = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       flagClr = 1'b0;
  logic       ackOut, addrFlag, evtIrq, dualHit, isTransmit;

  int checks = 0;
  int failures = 0;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  i2c_addr_recognizer i_i2c_addr_recognizer (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) evStart = 1'b1;
    @(negedge clk) evStart = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseStop();
    @(negedge clk) evStop = 1'b1;
    @(negedge clk) evStop = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clearFlag();
    @(negedge clk) flagClr = 1'b1;
    @(negedge clk) flagClr = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] d, input bit ack, input bit match,
                          input bit tx, input bit dual, input string req);
    exp_t e;
    e.ack = ack; e.match = match; e.tx = tx; e.dual = dual; e.req = req;
    expQ.push_back(e);
    @(negedge clk) begin byteData = d; byteValid = 1'b1; end
    @(negedge clk) byteValid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: compares design results against queued expectations
  initial begin
    forever begin
      @(posedge clk);
      if (byteValid) begin
        exp_t e;
        @(negedge clk);
        e = expQ.pop_front();
        check(ackOut == e.ack, e.req, "ackOut", ackOut, e.ack);
        @(negedge clk);
        check(addrFlag == e.match, e.req, "addrFlag", addrFlag, e.match);
        check(evtIrq == (e.match && cfgEvtIrqEn), e.req, "evtIrq", evtIrq,
              e.match && cfgEvtIrqEn);
        check(isTransmit == e.tx, e.req, "isTransmit", isTransmit, e.tx);
        check(dualHit == e.dual, e.req, "dualHit", dualHit, e.dual);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ackOut == 0, "R1", "ackOut", ackOut, 0);
    check(addrFlag == 0, "R1", "addrFlag", addrFlag, 0);
    check(evtIrq == 0, "R1", "evtIrq", evtIrq, 0);
    check(dualHit == 0, "R1", "dualHit", dualHit, 0);
    check(isTransmit == 0, "R1", "isTransmit", isTransmit, 0);

    // R2 7-bit write and read
    pulseStart(); sendByte(8'h74, 1, 1, 0, 0, "R2"); clearFlag(); pulseStop();
    pulseStart(); sendByte(8'h75, 1, 1, 1, 0, "R2"); clearFlag(); pulseStop();
    check(isTransmit == 0, "R8", "isTransmit after stop", isTransmit, 0);

    // R4 second address
    pulseStart(); sendByte(8'hA3, 1, 1, 1, 1, "R4"); clearFlag(); pulseStop();

    // R3 mismatch, then matching byte without start is ignored
    pulseStart();
    sendByte(8'h20, 0, 0, 0, 1, "R3");
    sendByte(8'h74, 0, 0, 0, 1, "R3");
    pulseStop();

    // R4 dual disabled
    cfgDualEn = 1'b0;
    pulseStart(); sendByte(8'hA3, 0, 0, 0, 1, "R4"); pulseStop();
    cfgDualEn = 1'b1;

    // R9 ack disabled
    cfgAckEn = 1'b0;
    pulseStart(); sendByte(8'h74, 0, 1, 0, 0, "R9"); clearFlag(); pulseStop();
    cfgAckEn = 1'b1;

    // R10 interrupt disabled, flag sticky
    cfgEvtIrqEn = 1'b0;
    pulseStart(); sendByte(8'h74, 1, 1, 0, 0, "R10");
    repeat (10) @(negedge clk);
    check(addrFlag == 1, "R10", "addrFlag sticky", addrFlag, 1);
    check(evtIrq == 0, "R10", "evtIrq masked", evtIrq, 0);
    cfgEvtIrqEn = 1'b1;
    @(negedge clk);
    check(evtIrq == 1, "R10", "evtIrq enabled", evtIrq, 1);
    clearFlag();
    check(addrFlag == 0, "R10", "addrFlag cleared", addrFlag, 0);
    pulseStop();

    // 10-bit mode, address 0x2C5: write header F4, read header F5
    cfgTenBit = 1'b1;
    cfgAddr   = 10'h2C5;
    pulseStart();
    sendByte(8'hF4, 1, 0, 0, 0, "R5");
    sendByte(8'hC5, 1, 1, 0, 0, "R5");
    clearFlag();
    pulseStart();
    sendByte(8'hF5, 1, 1, 1, 0, "R6");
    clearFlag();
    pulseStop();
    check(isTransmit == 0, "R8", "isTransmit after stop", isTransmit, 0);

    // R7/R8 read header with memory cleared by stop
    pulseStart(); sendByte(8'hF5, 0, 0, 0, 0, "R7"); pulseStop();

    // R11 wrong low byte, wrong header
    pulseStart();
    sendByte(8'hF4, 1, 0, 0, 0, "R11");
    sendByte(8'h33, 0, 0, 0, 0, "R11");
    pulseStop();
    pulseStart(); sendByte(8'hF6, 0, 0, 0, 0, "R11"); pulseStop();

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule